// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block builds the interrupt sources of a UART from the fill levels of its FIFOs, the receiver's per-character events and the four modem status lines. There are five sources: receive, transmit, receive timeout, modem status change and receive error. The receive-error source keeps overrun, break, parity and framing in separate bits, so software can clear them one at a time. Each source is latched into a raw status bit. A mask register gates the raw bits onto individual interrupt lines and onto one combined line.

Software reaches the unit through a small register port with four word addresses: raw status, mask, masked status and a write-one-to-clear register. The receive and transmit sources also clear themselves when the FIFO level moves back across its threshold. With the FIFOs switched off, each direction behaves as a single holding slot.

Top module: `uart_irq_unit`

## Requirements
- R1: While reset is low and after it is released, the mask register reads 0x00 and every interrupt output is low.
- R2: With FIFOs enabled, raw bit 0 (receive) sets one clock after `rx_level` first reaches the selected receive threshold. It clears one clock after the level is below that threshold.
- R3: With FIFOs enabled, raw bit 1 (transmit) sets one clock after `tx_level` first falls to or below the selected transmit threshold. It clears one clock after the level is above that threshold.
- R4: With FIFOs disabled, the receive source sets when `rx_level` goes from 0 to nonzero and clears when it returns to 0. The transmit source sets when `tx_level` becomes 0 and clears when it is nonzero.
- R5: Raw bit 2 (timeout) sets on the 32nd `bit_tick` counted while `rx_level` is nonzero. The count restarts on `rx_char` or `rx_read` and is held at zero while `rx_level` is 0. The bit clears one clock after `rx_level` is 0.
- R6: Each modem input passes through two synchronizing flops. Raw bit 3 sets on the third clock edge after any of the four lines changes.
- R7: One-clock strobes on `err_ovr`, `err_brk`, `err_par` and `err_frm` set raw bits 4, 5, 6 and 7 at the next edge. `irq_err` is the OR of those four bits after masking.
- R8: Each individual output equals its raw bit ANDed with the mask bit at the same position. `irq_any` is the OR of all masked bits.
- R9: The register addresses are 0 for raw status (read-only), 1 for mask (read/write), 2 for masked status (read-only) and 3 for clear, which is write-one-to-clear and reads 0. If a clear and a set event hit the same bit in one cycle, the bit ends up set.
- R10: A trigger-select code of 0, 1, 2, 3 or 4 picks 2, 4, 8, 12 or 14 entries of a 16-entry FIFO. Codes 5 to 7 behave as code 2 (8 entries).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFOs in use, 0 = single holding slot per direction |
| rx_sel | input | 3 | Receive threshold select code |
| tx_sel | input | 3 | Transmit threshold select code |
| rx_level | input | 5 | Receive FIFO fill level |
| tx_level | input | 5 | Transmit FIFO fill level |
| rx_char | input | 1 | Strobe: a character was received |
| rx_read | input | 1 | Strobe: software read the receive FIFO |
| bit_tick | input | 1 | One pulse per serial bit period |
| ri_n | input | 1 | Ring indicate, active low |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dsr_n | input | 1 | Data set ready, active low |
| err_ovr | input | 1 | Overrun error strobe |
| err_brk | input | 1 | Break error strobe |
| err_par | input | 1 | Parity error strobe |
| err_frm | input | 1 | Framing error strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rto | output | 1 | Masked receive-timeout interrupt |
| irq_ms | output | 1 | Masked modem-status interrupt |
| irq_err | output | 1 | OR of masked error bits |
| irq_any | output | 1 | OR of all masked sources |

## Verification
The bench drives FIFO levels exactly onto the thresholds of every select code, including the reserved ones. A design with an off-by-one compare would raise or drop receive and transmit one entry too early. The timeout is checked at tick 31 against tick 32, and again after a received character restarts the count; a counter that missed the restart would fire early. Another case puts a clear and an error strobe on the same bit in the same cycle, where a design that let the clear win would lose the event. A long random phase mixes mode switches, mask writes and strobes against a behavioural model, to catch latency slips in the modem synchronizer.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 8;

  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int IDX_RTO = 2;
  localparam int IDX_MS  = 3;
  localparam int IDX_OVR = 4;
  localparam int IDX_BRK = 5;
  localparam int IDX_PAR = 6;
  localparam int IDX_FRM = 7;

  localparam logic [1:0] ADDR_RAW  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_MIS  = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  // Threshold in entries for a select code; unknown codes act as half full.
  function automatic int trig_level(input logic [2:0] sel, input int depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter bit IS_TX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [2:0]    sel,
  input  logic [LW-1:0] level,
  output logic          cond,
  output logic          set_ev,
  output logic          clr_ev
);
  logic [LW-1:0] thr;
  logic          cond_q;

  always_comb begin
    if (fifo_en) thr = LW'(uart_irq_pkg::trig_level(sel, DEPTH));
    else if (IS_TX) thr = '0;
    else thr = LW'(1);
  end

  generate
    if (IS_TX) begin : g_tx
      assign cond = (level <= thr);
    end else begin : g_rx
      assign cond = (level >= thr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign set_ev = cond & ~cond_q;
  assign clr_ev = ~cond;
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TMO = 32,
  parameter int LW  = 5,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_char,
  input  logic          rx_read,
  input  logic          bit_tick,
  output logic          hit,
  output logic          empty,
  output logic [CW-1:0] cnt
);
  logic restart;

  assign empty   = (rx_level == '0);
  assign restart = empty | rx_char | rx_read;
  assign hit     = ~restart & bit_tick & (cnt == CW'(TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (restart)                       cnt <= '0;
    else if (bit_tick && cnt != CW'(TMO))   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_n,
  output logic         change
);
  logic [N-1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      prev <= '1;
    end else begin
      s1   <= lines_n;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign change = |(s2 ^ prev);
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] auto_clr,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] w1c_vec,
  output logic [NSRC-1:0] reg_rdata
);
  import uart_irq_pkg::*;

  assign w1c_vec = (reg_wr && reg_addr == ADDR_CLR) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~(auto_clr | w1c_vec)) | set_vec;
      if (reg_wr && reg_addr == ADDR_MASK) mask_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_RAW:  reg_rdata = raw_q;
      ADDR_MASK: reg_rdata = mask_q;
      ADDR_MIS:  reg_rdata = raw_q & mask_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int FIFO_DEPTH = 16,
  parameter int TMO_BITS   = 32,
  parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [2:0]    rx_sel,
  input  logic [2:0]    tx_sel,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          rx_char,
  input  logic          rx_read,
  input  logic          bit_tick,
  input  logic          ri_n,
  input  logic          cts_n,
  input  logic          dcd_n,
  input  logic          dsr_n,
  input  logic          err_ovr,
  input  logic          err_brk,
  input  logic          err_par,
  input  logic          err_frm,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_rto,
  output logic          irq_ms,
  output logic          irq_err,
  output logic          irq_any
);
  import uart_irq_pkg::*;

  localparam int CW = $clog2(TMO_BITS + 1);

  logic            rx_cond, rx_set, rx_clr;
  logic            tx_cond, tx_set, tx_clr;
  logic            rto_hit, rto_empty;
  logic [CW-1:0]   tmo_cnt;
  logic            ms_change;
  logic [NSRC-1:0] set_vec, auto_clr, raw_q, mask_q, w1c_vec, masked;

  uart_irq_level #(.DEPTH(FIFO_DEPTH), .LW(LW), .IS_TX(1'b0)) u_rxlvl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel(rx_sel),
    .level(rx_level), .cond(rx_cond), .set_ev(rx_set), .clr_ev(rx_clr)
  );

  uart_irq_level #(.DEPTH(FIFO_DEPTH), .LW(LW), .IS_TX(1'b1)) u_txlvl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel(tx_sel),
    .level(tx_level), .cond(tx_cond), .set_ev(tx_set), .clr_ev(tx_clr)
  );

  uart_irq_timeout #(.TMO(TMO_BITS), .LW(LW), .CW(CW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_char(rx_char),
    .rx_read(rx_read), .bit_tick(bit_tick), .hit(rto_hit),
    .empty(rto_empty), .cnt(tmo_cnt)
  );

  uart_irq_modem #(.N(4)) u_modem (
    .clk(clk), .rst_n(rst_n), .lines_n({dsr_n, dcd_n, cts_n, ri_n}),
    .change(ms_change)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_RX]  = rx_set;
    set_vec[IDX_TX]  = tx_set;
    set_vec[IDX_RTO] = rto_hit;
    set_vec[IDX_MS]  = ms_change;
    set_vec[IDX_OVR] = err_ovr;
    set_vec[IDX_BRK] = err_brk;
    set_vec[IDX_PAR] = err_par;
    set_vec[IDX_FRM] = err_frm;
    auto_clr          = '0;
    auto_clr[IDX_RX]  = rx_clr;
    auto_clr[IDX_TX]  = tx_clr;
    auto_clr[IDX_RTO] = rto_empty;
  end

  uart_irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .auto_clr(auto_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .raw_q(raw_q), .mask_q(mask_q), .w1c_vec(w1c_vec), .reg_rdata(reg_rdata)
  );

  assign masked  = raw_q & mask_q;
  assign irq_rx  = masked[IDX_RX];
  assign irq_tx  = masked[IDX_TX];
  assign irq_rto = masked[IDX_RTO];
  assign irq_ms  = masked[IDX_MS];
  assign irq_err = |masked[IDX_FRM:IDX_OVR];
  assign irq_any = |masked;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int TMO = 32,
  parameter int LW  = 5,
  parameter int CW  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_cond,
  input logic [7:0]    set_vec,
  input logic [7:0]    w1c_vec,
  input logic [7:0]    raw_q,
  input logic [7:0]    mask_q,
  input logic [CW-1:0] tmo_cnt,
  input logic [LW-1:0] rx_level,
  input logic          err_ovr,
  input logic          irq_any
);
  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq_any);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c_vec & ~set_vec)) |=> ((raw_q & $past(w1c_vec & ~set_vec)) == 8'h00));

  assert_tmo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_cnt <= CW'(TMO));

  assert_rto_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> !raw_q[2]);

  assert_err_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovr |=> raw_q[4]);

  assert_rx_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_cond |=> !raw_q[0]);
endmodule

bind uart_irq_unit uart_irq_chk #(.TMO(TMO_BITS), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_cond(rx_cond), .set_vec(set_vec),
  .w1c_vec(w1c_vec), .raw_q(raw_q), .mask_q(mask_q), .tmo_cnt(tmo_cnt),
  .rx_level(rx_level), .err_ovr(err_ovr), .irq_any(irq_any)
);

// File: tb/sim_uart_irq_unit.sv
`timescale 1ns/1ps
module sim_uart_irq_unit;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic [2:0] rx_sel = '0, tx_sel = '0;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic rx_char = 0, rx_read = 0, bit_tick = 0;
  logic [3:0] modem_n = 4'hF;
  logic [3:0] errs = '0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_rx, irq_tx, irq_rto, irq_ms, irq_err, irq_any;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .rx_level(rx_level), .tx_level(tx_level), .rx_char(rx_char), .rx_read(rx_read),
    .bit_tick(bit_tick), .ri_n(modem_n[0]), .cts_n(modem_n[1]), .dcd_n(modem_n[2]),
    .dsr_n(modem_n[3]), .err_ovr(errs[0]), .err_brk(errs[1]), .err_par(errs[2]),
    .err_frm(errs[3]), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
    .irq_ms(irq_ms), .irq_err(irq_err), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_raw, m_mask, m_cnt;
  bit m_prx, m_ptx;
  int sync_q[$];
  int m_prev;

  function automatic int thr_of(input int sel);
    case (sel)
      0: return 2;
      1: return 4;
      3: return 12;
      4: return 14;
      default: return 8;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_mask = 0; m_cnt = 0; m_prx = 0; m_ptx = 0;
      sync_q = '{15, 15}; m_prev = 15;
    end else begin
      int set_b, clr_b, s2;
      bit rc, tc;
      set_b = 0; clr_b = 0;
      rc = fifo_en ? (int'(rx_level) >= thr_of(rx_sel)) : (rx_level != 0);
      tc = fifo_en ? (int'(tx_level) <= thr_of(tx_sel)) : (tx_level == 0);
      if (rc && !m_prx) set_b |= 1;
      if (!rc) clr_b |= 1;
      if (tc && !m_ptx) set_b |= 2;
      if (!tc) clr_b |= 2;
      if (rx_level == 0 || rx_char || rx_read) m_cnt = 0;
      else if (bit_tick) begin
        if (m_cnt == 31) set_b |= 4;
        if (m_cnt < 32) m_cnt++;
      end
      if (rx_level == 0) clr_b |= 4;
      s2 = sync_q[0];
      if (s2 != m_prev) set_b |= 8;
      m_prev = s2;
      void'(sync_q.pop_front());
      sync_q.push_back(int'(modem_n));
      set_b |= int'(errs) << 4;
      if (reg_wr && reg_addr == 3) clr_b |= int'(reg_wdata);
      m_raw = (m_raw & ~clr_b & 8'hFF) | set_b;
      if (reg_wr && reg_addr == 1) m_mask = int'(reg_wdata);
      m_prx = rc; m_ptx = tc;
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      int mm, rd;
      mm = m_raw & m_mask;
      chk("R2 irq_rx", irq_rx, mm & 1);
      chk("R3 irq_tx", irq_tx, (mm >> 1) & 1);
      chk("R5 irq_rto", irq_rto, (mm >> 2) & 1);
      chk("R6 irq_ms", irq_ms, (mm >> 3) & 1);
      chk("R7 irq_err", irq_err, int'((mm >> 4) != 0));
      chk("R8 irq_any", irq_any, int'(mm != 0));
      case (reg_addr)
        2'd0: rd = m_raw;
        2'd1: rd = m_mask;
        2'd2: rd = mm;
        default: rd = 0;
      endcase
      chk("R9 reg_rdata", reg_rdata, rd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc(3);
    // R1: reset state
    reg_addr = 1;
    #1 chk("R1 mask at reset", reg_rdata, 0);
    chk("R1 irq_any at reset", irq_any, 0);
    rst_n = 1; reg_addr = 0;
    cyc(2);
    chk("R1 irq_any after reset", irq_any, 0);
    // R4: transmit slot empty after reset, FIFOs off
    chk("R4 raw tx after reset", reg_rdata, 8'h02);
    wr(1, 8'hFF);

    // R2 / R10: receive thresholds
    fifo_en = 1; tx_level = 16; rx_sel = 2; rx_level = 7;
    cyc(2); chk("R2 rx below 8", irq_rx, 0);
    rx_level = 8; cyc(1); chk("R2 rx at 8", irq_rx, 1);
    rx_level = 7; cyc(1); chk("R2 rx back to 7", irq_rx, 0);
    rx_sel = 5; rx_level = 8; cyc(1); chk("R10 reserved code 5 at 8", irq_rx, 1);
    rx_sel = 7; rx_level = 7; cyc(1); chk("R10 reserved code 7 at 7", irq_rx, 0);
    rx_sel = 0; rx_level = 2; cyc(1); chk("R2 code 0 at 2", irq_rx, 1);
    wr(3, 8'h01); chk("R9 w1c rx while level held", irq_rx, 0);

    // R3: transmit thresholds
    rx_level = 0; tx_sel = 3; tx_level = 13;
    cyc(1); chk("R3 tx at 13", irq_tx, 0);
    tx_level = 12; cyc(1); chk("R3 tx at 12", irq_tx, 1);
    tx_level = 13; cyc(1); chk("R3 tx back above", irq_tx, 0);
    tx_sel = 4; tx_level = 14; cyc(1); chk("R3 code 4 at 14", irq_tx, 1);

    // R4: single-slot mode
    fifo_en = 0; tx_level = 1; cyc(1); chk("R4 tx slot full", irq_tx, 0);
    rx_level = 1; cyc(1); chk("R4 rx slot filled", irq_rx, 1);
    tx_level = 0; cyc(1); chk("R4 tx slot emptied", irq_tx, 1);
    rx_level = 0; cyc(1); chk("R4 rx slot read", irq_rx, 0);

    // R5: receive timeout
    rx_level = 3; bit_tick = 1;
    cyc(31); chk("R5 no timeout at 31 ticks", irq_rto, 0);
    cyc(1);  chk("R5 timeout at 32 ticks", irq_rto, 1);
    rx_level = 0; cyc(1); chk("R5 cleared on empty", irq_rto, 0);
    rx_level = 3; cyc(20);
    rx_char = 1; cyc(1); rx_char = 0;
    cyc(31); chk("R5 restart after char", irq_rto, 0);
    cyc(1);  chk("R5 timeout after restart", irq_rto, 1);
    rx_level = 0; bit_tick = 0; cyc(1);

    // R6: modem change through synchronizer
    modem_n[1] = 0;
    cyc(2); chk("R6 not yet at edge 2", irq_ms, 0);
    cyc(1); chk("R6 set at edge 3", irq_ms, 1);
    wr(3, 8'h08); chk("R6 cleared by w1c", irq_ms, 0);

    // R7: error strobes
    errs = 4'b0100; cyc(1); errs = 0;
    chk("R7 parity sets err line", irq_err, 1);
    reg_addr = 0; #1 chk("R7 parity raw bit 6", (reg_rdata >> 6) & 1, 1);
    errs = 4'b0010; reg_wr = 1; reg_addr = 3; reg_wdata = 8'h20;
    cyc(1); errs = 0; reg_wr = 0; reg_addr = 0;
    #1 chk("R9 set wins over clear", (reg_rdata >> 5) & 1, 1);
    wr(3, 8'hF0); chk("R7 errors cleared", irq_err, 0);

    // R8: masking
    modem_n[1] = 1; cyc(3);
    wr(1, 8'h02);
    chk("R8 only tx enabled, tx raw set", irq_any, 1);
    chk("R8 ms masked off", irq_ms, 0);
    wr(1, 8'h00); chk("R8 all masked", irq_any, 0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      fifo_en  = ($urandom % 8) != 0;
      if ($urandom % 4 == 0) rx_sel = 3'($urandom);
      if ($urandom % 4 == 0) tx_sel = 3'($urandom);
      if ($urandom % 3 == 0) rx_level = LW'($urandom % 17);
      if ($urandom % 3 == 0) tx_level = LW'($urandom % 17);
      rx_char  = ($urandom % 40) == 0;
      rx_read  = ($urandom % 40) == 0;
      bit_tick = ($urandom % 2) == 0;
      if ($urandom % 30 == 0) modem_n[$urandom % 4] ^= 1'b1;
      errs     = ($urandom % 20 == 0) ? 4'($urandom) : 4'h0;
      reg_wr   = ($urandom % 6) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = 8'($urandom);
      cyc(1);
    end
    reg_wr = 0; errs = 0;
    cyc(2);
    finish_run();
  end
endmodule